// File: doc/BRIEF.md
# Linked-Descriptor Transfer Sequencer

This block walks a chain of transfer descriptors kept in memory. Each chain begins when software has set the descriptor-mode enable, loaded the address of the first descriptor, and pulsed the submit input. The block then reads that descriptor one 32-bit word at a time through a simple memory-read request/response port. It assembles the fields and presents the geometry of one transfer to a downstream data mover. That geometry is the source and destination addresses, the byte count minus one, the row count and the two strides. The block holds a request towards the mover until the mover reports done.

When a descriptor's transfer finishes, the block checks two flag bits in that descriptor. One flag can ask for an end-of-transfer interrupt, which is emitted together with the descriptor's id. The other flag decides what happens next: the chain either ends and the block returns to idle, or the block follows the next-descriptor pointer and fetches again. Only one descriptor is in flight at a time. While descriptor mode is enabled, any cyclic-repeat request from the surrounding logic is masked off.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `xfer_req_o` and `eot_irq_o` are all low.
- R2: A submit pulse on `start_i` starts a chain only when the block is idle and `hwdesc_en_i` is high. A submit pulse while `hwdesc_en_i` is low is ignored: `busy_o` stays low and no memory read is issued.
- R3: A descriptor is fetched as exactly twelve single-word reads at addresses base+0, base+4, … base+44, in rising order. Only one read is outstanding at a time. `mem_addr_o` is held until `mem_rvalid_i` returns that word.
- R4: The descriptor word offsets are fixed:
  - word 0 holds the flags;
  - word 1 holds the id;
  - words 2/3 hold the destination address;
  - words 4/5 hold the source address;
  - words 6/7 hold the next pointer;
  - word 8 holds the row count;
  - word 9 holds the byte count minus one;
  - word 10 holds the source stride;
  - word 11 holds the destination stride.

  Each 64-bit field is formed with its lower-addressed word as bits 31:0.
- R5: After the twelfth word arrives, `xfer_req_o` rises. All `xfer_*` fields carry the stored values unchanged, including the byte count minus one. They stay stable until a cycle with `xfer_done_i` high.
- R6: If flag bit 0 (last) is set, the block returns to idle (`busy_o` low) in the cycle after the done handshake.
- R7: If flag bit 0 is clear, the block fetches the descriptor at the next pointer after the done handshake. No memory read is issued while `xfer_req_o` is high.
- R8: If flag bit 1 is set, `eot_irq_o` pulses for exactly one cycle, in the cycle after the done handshake, with `eot_id_o` equal to that descriptor's id. If bit 1 is clear, no pulse is produced.
- R9: `cyclic_eff_o` equals `cyclic_req_i` when `hwdesc_en_i` is low and is forced low when `hwdesc_en_i` is high.
- R10: A submit pulse while a chain is running is ignored. The chain completes with exactly the transfers its descriptors describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transfer submit pulse |
| hwdesc_en_i | input | 1 | Descriptor mode enable |
| first_ptr_i | input | ADDR_W | Address of the first descriptor |
| cyclic_req_i | input | 1 | Cyclic repeat requested by surrounding logic |
| cyclic_eff_o | output | 1 | Cyclic repeat after masking by descriptor mode |
| busy_o | output | 1 | A chain is in progress |
| mem_req_o | output | 1 | Word read request, held until the response |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data word |
| xfer_req_o | output | 1 | Transfer request to the data mover |
| xfer_src_o | output | 64 | Source address |
| xfer_dst_o | output | 64 | Destination address |
| xfer_xlen_o | output | 32 | Byte count minus one |
| xfer_ylen_o | output | 32 | Row count (zero for 1D) |
| xfer_sstride_o | output | 32 | Source stride |
| xfer_dstride_o | output | 32 | Destination stride |
| xfer_id_o | output | 32 | Id of the descriptor in flight |
| xfer_done_i | input | 1 | Data mover finished the current transfer |
| eot_irq_o | output | 1 | End-of-transfer interrupt pulse |
| eot_id_o | output | 32 | Id of the descriptor that raised the interrupt |

## Verification
The assertions assume two things about the block's neighbours:
- `mem_rvalid_i` is only raised while a read is requested.
- `xfer_done_i` is only raised while a transfer is requested.

The hold properties on address and transfer fields depend on these assumptions. The bench's memory model answers only when it sees `mem_req_o` high and has counted out its latency. Its data-mover model raises done for a single cycle and only while `xfer_req_o` is high, so the stimulus never breaks these assumptions. The submit and enable inputs are driven between clock edges and held for whole cycles.

// File: rtl/sg_desc_pkg.sv
package sg_desc_pkg;

  localparam int DESC_WORDS = 12;

  // word offsets inside a descriptor
  localparam int W_FLAGS = 0;
  localparam int W_ID    = 1;
  localparam int W_DST   = 2;
  localparam int W_SRC   = 4;
  localparam int W_NEXT  = 6;
  localparam int W_YLEN  = 8;
  localparam int W_XLEN  = 9;
  localparam int W_SSTR  = 10;
  localparam int W_DSTR  = 11;

  localparam int FLAG_LAST = 0;
  localparam int FLAG_IRQ  = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } sg_state_e;

  // two 32-bit words to one 64-bit field, lower address in the low half
  function automatic logic [63:0] join64(input logic [31:0] lo, input logic [31:0] hi);
    return {hi, lo};
  endfunction

  // byte address of word number idx of the descriptor at base
  function automatic logic [63:0] word_addr(input logic [63:0] base, input logic [3:0] idx);
    return base + {58'd0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/sg_fetch_seq.sv
module sg_fetch_seq
  import sg_desc_pkg::*;
#(
  parameter int ADDR_W = 64,
  localparam int IDX_W = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_ptr_i,
  input  logic              run_i,
  input  logic              rvalid_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              word_cap_o,
  output logic              fetch_last_o
);

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [63:0]       base_ext;
  logic [63:0]       full_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= load_ptr_i;
      idx_q  <= '0;
    end else if (word_cap_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    base_ext = '0;
    base_ext[ADDR_W-1:0] = base_q;
    full_addr = word_addr(base_ext, idx_q);
  end

  assign addr_o       = full_addr[ADDR_W-1:0];
  assign idx_o        = idx_q;
  assign word_cap_o   = run_i && rvalid_i;
  assign fetch_last_o = word_cap_o && (idx_q == IDX_W'(DESC_WORDS - 1));

endmodule

// File: rtl/sg_desc_regs.sv
module sg_desc_regs
  import sg_desc_pkg::*;
#(
  localparam int IDX_W = $clog2(DESC_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      data_i,
  output logic [1:0]       flags_o,
  output logic [31:0]      id_o,
  output logic [63:0]      dst_o,
  output logic [63:0]      src_o,
  output logic [63:0]      next_o,
  output logic [31:0]      ylen_o,
  output logic [31:0]      xlen_o,
  output logic [31:0]      sstr_o,
  output logic [31:0]      dstr_o
);

  logic [31:0] word_q [DESC_WORDS];
  logic [1:0]  flag_q;

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    if (g == W_FLAGS) begin : g_flags
      always_ff @(posedge clk) begin
        if (!rst_n)                              flag_q <= '0;
        else if (wr_i && idx_i == IDX_W'(g))     flag_q <= data_i[1:0];
      end
      assign word_q[g] = '0;
    end else begin : g_data
      always_ff @(posedge clk) begin
        if (!rst_n)                              word_q[g] <= '0;
        else if (wr_i && idx_i == IDX_W'(g))     word_q[g] <= data_i;
      end
    end
  end

  assign flags_o = flag_q;
  assign id_o    = word_q[W_ID];
  assign dst_o   = join64(word_q[W_DST],  word_q[W_DST + 1]);
  assign src_o   = join64(word_q[W_SRC],  word_q[W_SRC + 1]);
  assign next_o  = join64(word_q[W_NEXT], word_q[W_NEXT + 1]);
  assign ylen_o  = word_q[W_YLEN];
  assign xlen_o  = word_q[W_XLEN];
  assign sstr_o  = word_q[W_SSTR];
  assign dstr_o  = word_q[W_DSTR];

endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_desc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        hwdesc_en_i,
  input  logic        fetch_last_i,
  input  logic        xfer_done_i,
  input  logic [1:0]  flags_i,
  input  logic [31:0] id_i,
  output sg_state_e   state_o,
  output logic        launch_o,
  output logic        follow_o,
  output logic        irq_o,
  output logic [31:0] irq_id_o
);

  sg_state_e   state_q;
  logic        desc_end;
  logic        irq_q;
  logic [31:0] irq_id_q;

  assign desc_end = (state_q == ST_XFER) && xfer_done_i;
  assign launch_o = (state_q == ST_IDLE) && start_i && hwdesc_en_i;
  assign follow_o = desc_end && !flags_i[FLAG_LAST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (launch_o)     state_q <= ST_FETCH;
        ST_FETCH: if (fetch_last_i) state_q <= ST_XFER;
        ST_XFER:  if (desc_end)     state_q <= flags_i[FLAG_LAST] ? ST_IDLE : ST_FETCH;
        default:                    state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      irq_id_q <= '0;
    end else begin
      irq_q <= desc_end && flags_i[FLAG_IRQ];
      if (desc_end && flags_i[FLAG_IRQ]) irq_id_q <= id_i;
    end
  end

  assign state_o  = state_q;
  assign irq_o    = irq_q;
  assign irq_id_o = irq_id_q;

endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
  import sg_desc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hwdesc_en_i,
  input  logic [ADDR_W-1:0] first_ptr_i,
  input  logic              cyclic_req_i,
  output logic              cyclic_eff_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_req_o,
  output logic [63:0]       xfer_src_o,
  output logic [63:0]       xfer_dst_o,
  output logic [31:0]       xfer_xlen_o,
  output logic [31:0]       xfer_ylen_o,
  output logic [31:0]       xfer_sstride_o,
  output logic [31:0]       xfer_dstride_o,
  output logic [31:0]       xfer_id_o,
  input  logic              xfer_done_i,
  output logic              eot_irq_o,
  output logic [31:0]       eot_id_o
);

  localparam int IDX_W = $clog2(DESC_WORDS);

  sg_state_e         state;
  logic              launch;
  logic              follow;
  logic              seq_load;
  logic [ADDR_W-1:0] seq_ptr;
  logic [IDX_W-1:0]  word_idx;
  logic              word_cap;
  logic              fetch_last;
  logic              desc_done;
  logic [1:0]        flags;
  logic [63:0]       next_ptr;

  assign seq_load  = launch || follow;
  assign seq_ptr   = launch ? first_ptr_i : next_ptr[ADDR_W-1:0];
  assign desc_done = xfer_req_o && xfer_done_i;

  sg_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .hwdesc_en_i  (hwdesc_en_i),
    .fetch_last_i (fetch_last),
    .xfer_done_i  (xfer_done_i),
    .flags_i      (flags),
    .id_i         (xfer_id_o),
    .state_o      (state),
    .launch_o     (launch),
    .follow_o     (follow),
    .irq_o        (eot_irq_o),
    .irq_id_o     (eot_id_o)
  );

  sg_fetch_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (seq_load),
    .load_ptr_i   (seq_ptr),
    .run_i        (state == ST_FETCH),
    .rvalid_i     (mem_rvalid_i),
    .addr_o       (mem_addr_o),
    .idx_o        (word_idx),
    .word_cap_o   (word_cap),
    .fetch_last_o (fetch_last)
  );

  sg_desc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (word_cap),
    .idx_i   (word_idx),
    .data_i  (mem_rdata_i),
    .flags_o (flags),
    .id_o    (xfer_id_o),
    .dst_o   (xfer_dst_o),
    .src_o   (xfer_src_o),
    .next_o  (next_ptr),
    .ylen_o  (xfer_ylen_o),
    .xlen_o  (xfer_xlen_o),
    .sstr_o  (xfer_sstride_o),
    .dstr_o  (xfer_dstride_o)
  );

  assign busy_o       = (state != ST_IDLE);
  assign mem_req_o    = (state == ST_FETCH);
  assign xfer_req_o   = (state == ST_XFER);
  assign cyclic_eff_o = cyclic_req_i && !hwdesc_en_i;

endmodule

// File: rtl/sg_desc_walker_chk.sv
module sg_desc_walker_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              hwdesc_en_i,
  input logic              cyclic_eff_o,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              xfer_req_o,
  input logic [63:0]       xfer_src_o,
  input logic [63:0]       xfer_dst_o,
  input logic [31:0]       xfer_xlen_o,
  input logic [31:0]       xfer_id_o,
  input logic              xfer_done_i,
  input logic              eot_irq_o,
  input logic              fetch_last,
  input logic              desc_done
);

  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !xfer_req_o && !eot_irq_o);

  assert_ignore_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !hwdesc_en_i) |=> !busy_o);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> mem_req_o && $stable(mem_addr_o));

  assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_last |=> xfer_req_o);

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_done_i) |=> xfer_req_o && $stable(xfer_src_o)
      && $stable(xfer_dst_o) && $stable(xfer_xlen_o) && $stable(xfer_id_o));

  assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && xfer_req_o));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_irq_o |-> $past(desc_done));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_irq_o |=> !eot_irq_o);

  assert_cyclic_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hwdesc_en_i |-> !cyclic_eff_o);

endmodule

bind sg_desc_walker sg_desc_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .hwdesc_en_i  (hwdesc_en_i),
  .cyclic_eff_o (cyclic_eff_o),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .xfer_req_o   (xfer_req_o),
  .xfer_src_o   (xfer_src_o),
  .xfer_dst_o   (xfer_dst_o),
  .xfer_xlen_o  (xfer_xlen_o),
  .xfer_id_o    (xfer_id_o),
  .xfer_done_i  (xfer_done_i),
  .eot_irq_o    (eot_irq_o),
  .fetch_last   (fetch_last),
  .desc_done    (desc_done)
);

// File: tb/sg_desc_walker_tb_top.sv
`timescale 1ns/1ps
module sg_desc_walker_tb_top;

  localparam int ADDR_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start_i = 0, hwdesc_en_i = 0, cyclic_req_i = 0;
  logic [ADDR_W-1:0] first_ptr_i = '0;
  logic              cyclic_eff_o, busy_o, mem_req_o, xfer_req_o, eot_irq_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_rvalid = 0;
  logic [31:0]       mem_rdata = '0;
  logic [63:0]       xfer_src_o, xfer_dst_o;
  logic [31:0]       xfer_xlen_o, xfer_ylen_o, xfer_sstride_o, xfer_dstride_o, xfer_id_o, eot_id_o;
  logic              xfer_done = 0;

  sg_desc_walker #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hwdesc_en_i(hwdesc_en_i),
    .first_ptr_i(first_ptr_i), .cyclic_req_i(cyclic_req_i), .cyclic_eff_o(cyclic_eff_o),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .xfer_req_o(xfer_req_o),
    .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o), .xfer_xlen_o(xfer_xlen_o),
    .xfer_ylen_o(xfer_ylen_o), .xfer_sstride_o(xfer_sstride_o), .xfer_dstride_o(xfer_dstride_o),
    .xfer_id_o(xfer_id_o), .xfer_done_i(xfer_done), .eot_irq_o(eot_irq_o), .eot_id_o(eot_id_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // memory and logs
  logic [31:0] mem [256];
  logic [63:0] rd_log [64];
  int          rd_n = 0;
  int          rd_lat = 0;
  int          wcnt = 0;
  int          overlap = 0;
  logic [63:0] x_src [8];
  logic [63:0] x_dst [8];
  logic [31:0] x_xlen [8];
  logic [31:0] x_ylen [8];
  logic [31:0] x_ss [8];
  logic [31:0] x_ds [8];
  logic [31:0] x_id [8];
  int          xn = 0;
  int          dn_lat = 1;
  int          dcnt = 0;
  logic [31:0] irq_ids [8];
  int          irq_n = 0;
  int          irq_run = 0;
  int          irq_run_max = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 0;
      wcnt = 0;
    end else if (mem_req_o && !mem_rvalid && wcnt >= rd_lat) begin
      mem_rvalid = 1;
      mem_rdata  = mem[mem_addr_o[9:2]];
      if (rd_n < 64) rd_log[rd_n] = mem_addr_o;
      rd_n++;
      wcnt = 0;
    end else begin
      mem_rvalid = 0;
      if (mem_req_o) wcnt++;
    end
    if (mem_req_o && xfer_req_o) overlap++;
  end

  // data mover model and interrupt monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      xfer_done = 0;
      dcnt = 0;
    end else if (xfer_req_o && !xfer_done && dcnt >= dn_lat) begin
      xfer_done = 1;
      if (xn < 8) begin
        x_src[xn] = xfer_src_o;   x_dst[xn] = xfer_dst_o;
        x_xlen[xn] = xfer_xlen_o; x_ylen[xn] = xfer_ylen_o;
        x_ss[xn] = xfer_sstride_o; x_ds[xn] = xfer_dstride_o;
        x_id[xn] = xfer_id_o;
      end
      xn++;
      dcnt = 0;
    end else begin
      xfer_done = 0;
      if (xfer_req_o) dcnt++;
    end
    if (rst_n && eot_irq_o) begin
      if (irq_n < 8) irq_ids[irq_n] = eot_id_o;
      irq_n++;
      irq_run++;
      if (irq_run > irq_run_max) irq_run_max = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic put_desc(input int base, input logic [31:0] flags, input logic [31:0] id,
                          input logic [63:0] dst, input logic [63:0] src, input logic [63:0] nxt,
                          input logic [31:0] ylen, input logic [31:0] xlen,
                          input logic [31:0] ss, input logic [31:0] ds);
    int w;
    w = base >> 2;
    mem[w+0] = flags;      mem[w+1] = id;
    mem[w+2] = dst[31:0];  mem[w+3] = dst[63:32];
    mem[w+4] = src[31:0];  mem[w+5] = src[63:32];
    mem[w+6] = nxt[31:0];  mem[w+7] = nxt[63:32];
    mem[w+8] = ylen;       mem[w+9] = xlen;
    mem[w+10] = ss;        mem[w+11] = ds;
  endtask

  task automatic clear_logs();
    rd_n = 0; xn = 0; irq_n = 0; overlap = 0; irq_run_max = 0;
  endtask

  task automatic submit(input logic [63:0] ptr);
    @(negedge clk);
    first_ptr_i = ptr;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "mem_req after reset", mem_req_o, 0);
    chk("R1", "xfer_req after reset", xfer_req_o, 0);
    chk("R1", "irq after reset", eot_irq_o, 0);
  endtask

  task automatic t_no_enable();
    clear_logs();
    hwdesc_en_i = 0;
    put_desc(32'h40, 32'h3, 32'h11, 64'h1, 64'h2, 64'h0, 0, 7, 0, 0);
    submit(64'h40);
    repeat (6) @(negedge clk);
    chk("R2", "busy with enable low", busy_o, 0);
    chk("R2", "reads with enable low", rd_n, 0);
  endtask

  task automatic t_single();
    clear_logs();
    hwdesc_en_i = 1;
    rd_lat = 0; dn_lat = 3;
    put_desc(32'h40, 32'h3, 32'hA5A5_0001, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
             64'h0, 32'd0, 32'd255, 32'd0, 32'd0);
    submit(64'h40);
    wait_idle();
    chk("R3", "read count", rd_n, 12);
    for (int k = 0; k < 12; k++) chk("R3", "read address", rd_log[k], 64'h40 + 4*k);
    chk("R4", "dst assembled", x_dst[0], 64'h1111_2222_3333_4444);
    chk("R4", "src assembled", x_src[0], 64'h5555_6666_7777_8888);
    chk("R5", "xlen passed unchanged", x_xlen[0], 255);
    chk("R5", "ylen zero for 1D", x_ylen[0], 0);
    chk("R5", "transfer count", xn, 1);
    chk("R6", "idle after last", busy_o, 0);
    chk("R8", "irq count", irq_n, 1);
    chk("R8", "irq id", irq_ids[0], 32'hA5A5_0001);
    chk("R8", "irq one cycle", irq_run_max, 1);
  endtask

  task automatic t_chain();
    clear_logs();
    hwdesc_en_i = 1;
    rd_lat = 2; dn_lat = 5;
    put_desc(32'h100, 32'h2, 32'h0000_00A0, 64'hD0, 64'hC0, 64'h200, 32'd3, 32'd63, 32'h100, 32'h80);
    put_desc(32'h200, 32'h0, 32'h0000_00B0, 64'hD1, 64'hC1, 64'h300, 32'd0, 32'd15, 32'd0, 32'd0);
    put_desc(32'h300, 32'h3, 32'h0000_00C0, 64'hD2, 64'hC2, 64'h0,   32'd1, 32'd7, 32'h20, 32'h40);
    submit(64'h100);
    wait_idle();
    chk("R7", "chain transfers", xn, 3);
    chk("R7", "chain reads", rd_n, 36);
    chk("R7", "second fetch base", rd_log[12], 64'h200);
    chk("R7", "third fetch base", rd_log[24], 64'h300);
    chk("R7", "no read during transfer", overlap, 0);
    chk("R4", "ylen of first", x_ylen[0], 3);
    chk("R4", "src stride of first", x_ss[0], 32'h100);
    chk("R4", "dst stride of first", x_ds[0], 32'h80);
    chk("R4", "dst stride of third", x_ds[2], 32'h40);
    chk("R4", "id order", {x_id[0][7:0], x_id[1][7:0], x_id[2][7:0]}, 64'hA0B0C0);
    chk("R8", "irq only when flagged", irq_n, 2);
    chk("R8", "irq ids", {irq_ids[0][7:0], irq_ids[1][7:0]}, 64'hA0C0);
    chk("R6", "idle after chain", busy_o, 0);
  endtask

  task automatic t_restart_ignored();
    clear_logs();
    hwdesc_en_i = 1;
    rd_lat = 0; dn_lat = 20;
    put_desc(32'h40, 32'h1, 32'h77, 64'hE0, 64'hF0, 64'h0, 0, 3, 0, 0);
    submit(64'h40);
    for (int i = 0; i < 200 && !xfer_req_o; i++) @(negedge clk);
    submit(64'h40);
    wait_idle();
    chk("R10", "transfers with second submit", xn, 1);
    chk("R10", "reads with second submit", rd_n, 12);
    chk("R8", "no irq when bit clear", irq_n, 0);
  endtask

  task automatic t_cyclic();
    @(negedge clk);
    cyclic_req_i = 1; hwdesc_en_i = 1;
    @(negedge clk);
    chk("R9", "cyclic masked", cyclic_eff_o, 0);
    hwdesc_en_i = 0;
    @(negedge clk);
    chk("R9", "cyclic passed", cyclic_eff_o, 1);
    cyclic_req_i = 0;
    @(negedge clk);
    chk("R9", "cyclic off", cyclic_eff_o, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_enable();
    t_single();
    t_chain();
    t_restart_ignored();
    t_cyclic();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule